// File: doc/BRIEF.md
# Single-Cycle Six-Instruction Processor Core

This block is a 32-bit processor core that fetches, decodes, executes and retires one instruction in every clock cycle. It handles unsigned add and unsigned subtract between registers, OR with a zero-extended immediate, word load, word store and a branch taken when two registers are equal. The core holds the program counter, a register file of 32 words with two combinational read ports and one clocked write port, an immediate extender, an ALU and the instruction decoder.

Instruction and data storage are word arrays inside the core. Both read combinationally, and the data array is written on the clock edge. A testbench or a surrounding system loads the arrays before reset is released. The outputs show the current fetch address and instruction, the register write that retires in this cycle and the data store that retires in this cycle, so every architectural effect can be observed.

Top module: `sc_core`

## Requirements
- R1: For opcode 6'h00 with funct 6'h21, R[rd] receives R[rs] + R[rt] modulo 2^32. The destination is rd, instr[15:11].
- R2: For opcode 6'h00 with funct 6'h23, R[rd] receives R[rs] - R[rt] modulo 2^32. A result that wraps below zero is kept as the two's-complement value.
- R3: For opcode 6'h0D, R[rt] receives R[rs] OR {16'h0, instr[15:0]}. The destination is rt, instr[20:16], and bits 31:16 of the immediate are zero even when bit 15 is set.
- R4: For opcode 6'h23, R[rt] receives the data word at byte address R[rs] + sign-extended instr[15:0]. Negative offsets reach lower addresses.
- R5: For opcode 6'h2B, R[rt] is written to the data word at R[rs] + sign-extended imm16 on the clock edge, and no register is written. A later load from that address returns the stored value.
- R6: For opcode 6'h04, when R[rs] equals R[rt], the next PC is PC + 4 + (sign-extended imm16 << 2). This covers forward and backward targets.
- R7: For opcode 6'h04 when the registers differ, and for every other instruction, the next PC is PC + 4.
- R8: Register 0 reads as zero. A write that targets it is discarded, and the write-enable output stays low.
- R9: An opcode outside the six, or opcode 6'h00 with any funct other than 6'h21 and 6'h23, writes neither a register nor memory. The PC still advances by 4.
- R10: Synchronous active-high reset sets the PC to 0. After reset the first instruction is fetched from word 0.
- R11: Instruction and data arrays are indexed by address bits above bit 1. The low two address bits do not affect which word is read or written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pc_o | output | 32 | Address of the instruction being executed |
| instr_o | output | 32 | Instruction word being executed |
| rf_we_o | output | 1 | A register write retires at the next edge |
| rf_waddr_o | output | 5 | Register written |
| rf_wdata_o | output | 32 | Value written to the register |
| dm_we_o | output | 1 | A data store retires at the next edge |
| dm_addr_o | output | 32 | Byte address of the data access |
| dm_wdata_o | output | 32 | Data stored |

## Verification
A fixed program runs through every instruction kind. For the ALU it uses operands that separate the operations: OR with an immediate whose bit 15 is set separates zero-extension from sign-extension, and a subtract that goes negative separates wrap-around from saturation. Loads use zero, negative and unaligned offsets, so the bench can see the address adder, the sign extension and the dropped low bits.

The program also includes:
- a store followed by a load from the same address, which confirms the write.
- a write to register 0 followed by a read of it.
- an unknown opcode.
- one branch that is not taken, one taken forward and one taken backward, which separate the three next-PC cases.

Directed tests then cover reset during a run and an R-type funct outside the supported pair.

// File: rtl/sc_core.sv
module sc_core #(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  parameter int NREGS      = 32
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] pc_o,
  output logic [31:0] instr_o,
  output logic        rf_we_o,
  output logic [4:0]  rf_waddr_o,
  output logic [31:0] rf_wdata_o,
  output logic        dm_we_o,
  output logic [31:0] dm_addr_o,
  output logic [31:0] dm_wdata_o
);
  localparam int IAW = $clog2(IMEM_WORDS);
  localparam int DAW = $clog2(DMEM_WORDS);
  localparam logic [5:0] OP_RTYPE = 6'h00, OP_ORI = 6'h0D, OP_LW = 6'h23,
                         OP_SW = 6'h2B, OP_BEQ = 6'h04;
  localparam logic [5:0] FN_ADDU = 6'h21, FN_SUBU = 6'h23;

  logic [31:0] imem [IMEM_WORDS];
  logic [31:0] dmem [DMEM_WORDS];
  logic [31:0] regs [NREGS];
  logic [31:0] pc_q, instr, a_val, b_val, imm_ext, alu_b, alu_y, pc_seq, br_tgt, pc_nxt, rd_data;
  logic [5:0]  op, fn;
  logic [4:0]  rs, rt, rd, dst;
  logic        is_r, is_ori, is_lw, is_sw, is_beq, reg_wr, take;

  initial for (int i = 0; i < IMEM_WORDS; i++) imem[i] = '0;

  assign instr = imem[pc_q[IAW+1:2]];
  assign op = instr[31:26];
  assign rs = instr[25:21];
  assign rt = instr[20:16];
  assign rd = instr[15:11];
  assign fn = instr[5:0];

  assign is_r   = (op == OP_RTYPE) && (fn == FN_ADDU || fn == FN_SUBU);
  assign is_ori = op == OP_ORI;
  assign is_lw  = op == OP_LW;
  assign is_sw  = op == OP_SW;
  assign is_beq = op == OP_BEQ;
  assign reg_wr = is_r || is_ori || is_lw;
  assign dst    = is_r ? rd : rt;

  assign a_val   = (rs == 5'd0) ? 32'd0 : regs[rs];
  assign b_val   = (rt == 5'd0) ? 32'd0 : regs[rt];
  assign imm_ext = is_ori ? {16'h0, instr[15:0]} : {{16{instr[15]}}, instr[15:0]};
  assign alu_b   = is_r || is_beq ? b_val : imm_ext;

  always_comb begin
    if (is_r)        alu_y = (fn == FN_SUBU) ? a_val - alu_b : a_val + alu_b;
    else if (is_ori) alu_y = a_val | alu_b;
    else if (is_beq) alu_y = a_val - alu_b;
    else             alu_y = a_val + alu_b;
  end

  assign rd_data = dmem[alu_y[DAW+1:2]];
  assign take    = is_beq && (alu_y == 32'd0);
  assign pc_seq  = pc_q + 32'd4;
  assign br_tgt  = pc_seq + {imm_ext[29:0], 2'b00};
  assign pc_nxt  = take ? br_tgt : pc_seq;

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_nxt;
  end

  always_ff @(posedge clk) begin
    if (!rst && rf_we_o) regs[dst] <= rf_wdata_o;
    if (!rst && dm_we_o) dmem[alu_y[DAW+1:2]] <= b_val;
  end

  assign pc_o       = pc_q;
  assign instr_o    = instr;
  assign rf_we_o    = reg_wr && (dst != 5'd0);
  assign rf_waddr_o = dst;
  assign rf_wdata_o = is_lw ? rd_data : alu_y;
  assign dm_we_o    = is_sw;
  assign dm_addr_o  = alu_y;
  assign dm_wdata_o = b_val;

  p_reset_pc_r10: assert property (@(posedge clk) rst |=> pc_o == 32'd0);
  p_seq_pc_r7: assert property (@(posedge clk) disable iff (rst)
    !take |=> pc_o == $past(pc_o) + 32'd4);
  p_branch_pc_r6: assert property (@(posedge clk) disable iff (rst)
    take |=> pc_o == $past(br_tgt));
  p_store_no_reg_r5: assert property (@(posedge clk) disable iff (rst)
    dm_we_o |-> !rf_we_o);
  p_zero_reg_r8: assert property (@(posedge clk) disable iff (rst)
    rf_we_o |-> rf_waddr_o != 5'd0);
  p_unknown_nop_r9: assert property (@(posedge clk) disable iff (rst)
    !(is_r || is_ori || is_lw || is_sw || is_beq) |-> !rf_we_o && !dm_we_o);
endmodule

// File: tb/sc_core_test.sv
module sc_core_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] pc_o, instr_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
  logic        rf_we_o, dm_we_o;
  logic [4:0]  rf_waddr_o;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sc_core uut (.clk(clk), .rst(rst), .pc_o(pc_o), .instr_o(instr_o), .rf_we_o(rf_we_o),
    .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o), .dm_we_o(dm_we_o),
    .dm_addr_o(dm_addr_o), .dm_wdata_o(dm_wdata_o));

  function automatic logic [31:0] enc_r(input logic [4:0] s, input logic [4:0] t, input logic [4:0] d, input logic [5:0] f);
    return {6'h00, s, t, d, 5'd0, f};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] o, input logic [4:0] s, input logic [4:0] t, input logic [15:0] im);
    return {o, s, t, im};
  endfunction

  localparam logic [31:0] PROG [17] = '{
    enc_i(6'h0D, 5'd0, 5'd1, 16'h0014),
    enc_i(6'h0D, 5'd0, 5'd2, 16'h8001),
    enc_r(5'd1, 5'd2, 5'd3, 6'h21),
    enc_r(5'd1, 5'd2, 5'd4, 6'h23),
    enc_i(6'h23, 5'd1, 5'd5, 16'h0000),
    enc_i(6'h23, 5'd1, 5'd6, 16'hFFFC),
    enc_i(6'h23, 5'd1, 5'd7, 16'h0003),
    enc_i(6'h2B, 5'd1, 5'd3, 16'h0008),
    enc_i(6'h23, 5'd0, 5'd8, 16'h001C),
    enc_i(6'h0D, 5'd1, 5'd0, 16'h00FF),
    enc_r(5'd0, 5'd1, 5'd9, 6'h21),
    32'hFC22_1234,
    enc_i(6'h04, 5'd1, 5'd2, 16'h0005),
    enc_i(6'h04, 5'd3, 5'd8, 16'h0002),
    enc_i(6'h0D, 5'd0, 5'd10, 16'hBEEF),
    enc_i(6'h04, 5'd0, 5'd0, 16'hFFFF),
    enc_i(6'h04, 5'd0, 5'd0, 16'hFFFD)
  };

  typedef struct packed {
    logic [31:0] pc; logic we; logic [4:0] wa; logic [31:0] wd;
    logic dwe; logic [31:0] da; logic [31:0] dd;
  } vec_t;

  localparam vec_t VECS [18] = '{
    '{32'h00, 1'b1, 5'd1,  32'h0000_0014, 1'b0, 32'h0, 32'h0},
    '{32'h04, 1'b1, 5'd2,  32'h0000_8001, 1'b0, 32'h0, 32'h0},
    '{32'h08, 1'b1, 5'd3,  32'h0000_8015, 1'b0, 32'h0, 32'h0},
    '{32'h0C, 1'b1, 5'd4,  32'hFFFF_8013, 1'b0, 32'h0, 32'h0},
    '{32'h10, 1'b1, 5'd5,  32'h0000_00AA, 1'b0, 32'h0, 32'h0},
    '{32'h14, 1'b1, 5'd6,  32'h8765_4321, 1'b0, 32'h0, 32'h0},
    '{32'h18, 1'b1, 5'd7,  32'h0000_00AA, 1'b0, 32'h0, 32'h0},
    '{32'h1C, 1'b0, 5'd0,  32'h0,         1'b1, 32'h1C, 32'h0000_8015},
    '{32'h20, 1'b1, 5'd8,  32'h0000_8015, 1'b0, 32'h0, 32'h0},
    '{32'h24, 1'b0, 5'd0,  32'h0,         1'b0, 32'h0, 32'h0},
    '{32'h28, 1'b1, 5'd9,  32'h0000_0014, 1'b0, 32'h0, 32'h0},
    '{32'h2C, 1'b0, 5'd0,  32'h0,         1'b0, 32'h0, 32'h0},
    '{32'h30, 1'b0, 5'd0,  32'h0,         1'b0, 32'h0, 32'h0},
    '{32'h34, 1'b0, 5'd0,  32'h0,         1'b0, 32'h0, 32'h0},
    '{32'h40, 1'b0, 5'd0,  32'h0,         1'b0, 32'h0, 32'h0},
    '{32'h38, 1'b1, 5'd10, 32'h0000_BEEF, 1'b0, 32'h0, 32'h0},
    '{32'h3C, 1'b0, 5'd0,  32'h0,         1'b0, 32'h0, 32'h0},
    '{32'h3C, 1'b0, 5'd0,  32'h0,         1'b0, 32'h0, 32'h0}
  };

  function automatic string req_of(input int i);
    case (i)
      0, 1: return "R3";
      2: return "R1";
      3: return "R2";
      4, 5: return "R4";
      6: return "R11";
      7, 8: return "R5";
      9, 10: return "R8";
      11: return "R9";
      12: return "R7";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    #1;
    for (int i = 0; i < 17; i++) uut.imem[i] = PROG[i];
    uut.dmem[4] = 32'h8765_4321;
    uut.dmem[5] = 32'h0000_00AA;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R10", "pc in reset", pc_o, 32'h0);
    rst = 1'b0;
    check("R10", "first fetch", instr_o, PROG[0]);
    for (int i = 0; i < 18; i++) begin
      check(req_of(i), $sformatf("step %0d pc", i), pc_o, VECS[i].pc);
      check(req_of(i), $sformatf("step %0d reg we", i), {31'd0, rf_we_o}, {31'd0, VECS[i].we});
      if (VECS[i].we) begin
        check(req_of(i), $sformatf("step %0d waddr", i), {27'd0, rf_waddr_o}, {27'd0, VECS[i].wa});
        check(req_of(i), $sformatf("step %0d wdata", i), rf_wdata_o, VECS[i].wd);
      end
      check(req_of(i), $sformatf("step %0d mem we", i), {31'd0, dm_we_o}, {31'd0, VECS[i].dwe});
      if (VECS[i].dwe) begin
        check(req_of(i), $sformatf("step %0d maddr", i), dm_addr_o, VECS[i].da);
        check(req_of(i), $sformatf("step %0d mdata", i), dm_wdata_o, VECS[i].dd);
      end
      @(negedge clk);
    end

    // R10: reset in the middle of a run returns fetch to word 0
    rst = 1'b1;
    @(negedge clk);
    check("R10", "pc after mid-run reset", pc_o, 32'h0);
    // R9: R-type with unsupported funct writes nothing and steps the PC
    uut.imem[0] = enc_r(5'd1, 5'd1, 5'd11, 6'h00);
    uut.imem[1] = enc_r(5'd0, 5'd11, 5'd12, 6'h21);
    rst = 1'b0;
    #1;
    check("R9", "bad funct reg we", {31'd0, rf_we_o}, 32'd0);
    check("R9", "bad funct mem we", {31'd0, dm_we_o}, 32'd0);
    @(negedge clk);
    check("R9", "pc after bad funct", pc_o, 32'h4);
    // R5/R11: earlier store landed in word 7 (address 0x1C..0x1F)
    uut.imem[2] = enc_i(6'h23, 5'd0, 5'd13, 16'h001E);
    @(negedge clk);
    check("R11", "unaligned load reads stored word", rf_wdata_o, 32'h0000_8015);
    finish_run();
  end
endmodule